// File: doc/BRIEF.md
# Shared Message Interrupt Bank

This block collects message-signalled interrupts that arrive as 32-bit posted writes. It holds eight 32-bit shared registers. A write to the index register names one shared register and one bit inside it through fields of the written data word. That bit is ORed into the register, and the block raises its interrupt request towards the controller core.

Software drains the bank by reading. A read of a shared register returns its contents and clears it in the same access. A summary register shows, one bit per shared register, which ones still hold bits, so a handler can go straight to the registers that need service. The interrupt output stays high while any shared register is non-zero.

The register port has separate read and write channels, so a posted write and a draining read can occur in the same cycle. Read data is combinational from the current state. Write effects and read clears take hold at the next rising clock edge.

Top module: `msi_bank_top`

## Requirements
- R1: After reset all shared registers are zero, the summary reads zero and `irqOut` is low.
- R2: A write to offset 0x140 sets bit `wrData[28:24]` of shared register `wrData[31:29]`. The bit is visible from the next cycle on.
- R3: A read of offset 0x10*k, for k from 0 to 7, returns shared register k and clears it to zero at the clock edge that ends the read.
- R4: A read of offset 0x120 returns a word whose bit k is set exactly when shared register k is non-zero. Bits 31:8 read as zero.
- R5: `irqOut` is high in every cycle after the state holds a non-zero shared register. It goes low once all shared registers have been read clear.
- R6: A write to any offset other than 0x140 changes no shared register and does not raise `irqOut`.
- R7: When a read clears shared register k in the same cycle that an index write sets a bit in register k, only the newly set bit remains afterwards.
- R8: Setting a bit keeps all other bits of the register, and setting a bit that is already set leaves the register unchanged.
- R9: A read of an offset that is neither a shared register nor the summary register, the index register included, returns zero and clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 9 | Write byte offset within the region |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe; a read of a shared register clears it |
| rdAddr | input | 9 | Read byte offset within the region |
| rdData | output | 32 | Read data, combinational, zero when not reading |
| irqOut | output | 1 | Interrupt request, high while any shared register is non-zero |

## Verification
The hardest case to reach is a read clear and an index write aimed at the same register in one cycle. Only the separate read and write channels make this case possible. Random stimulus picks the read and write register from a small range, so such collisions happen often. Directed steps then force the exact collision on a register that already held other bits. A reference model drains and sets its copy in the same order as the design, and checks every read word and the interrupt level in each cycle.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;
  localparam int SEL_W = 3;
  localparam int BIT_W = 5;

  typedef enum logic [1:0] {RD_NONE, RD_BANK, RD_SUM} rdSel_e;

  typedef struct packed {
    logic             setStb;
    logic [SEL_W-1:0] setReg;
    logic [BIT_W-1:0] setBit;
    logic             clrStb;
    logic [SEL_W-1:0] clrReg;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/msi_bank_ctrl.sv
module msi_bank_ctrl
  import msi_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int NUM_REGS = 8,
  parameter int STRIDE_LSB = 4,
  parameter logic [ADDR_W-1:0] IDX_OFF = 9'h140,
  parameter logic [ADDR_W-1:0] SUM_OFF = 9'h120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           stb
);
  localparam int FIELD_LSB = DATA_W - SEL_W - BIT_W;

  logic idxHit, bankHit, sumHit;
  logic unusedLowBits;

  assign unusedLowBits = ^wrData[FIELD_LSB-1:0];
  assign idxHit  = wrEn && (wrAddr == IDX_OFF);
  assign bankHit = rdEn && (rdAddr[STRIDE_LSB-1:0] == '0)
                   && ((rdAddr >> STRIDE_LSB) < ADDR_W'(NUM_REGS));
  assign sumHit  = rdEn && (rdAddr == SUM_OFF);

  always_comb begin
    stb.setStb = idxHit;
    stb.setReg = wrData[DATA_W-1 -: SEL_W];
    stb.setBit = wrData[FIELD_LSB +: BIT_W];
    stb.clrStb = bankHit;
    stb.clrReg = rdAddr[STRIDE_LSB +: SEL_W];
    if (bankHit)     stb.rdSel = RD_BANK;
    else if (sumHit) stb.rdSel = RD_SUM;
    else             stb.rdSel = RD_NONE;
  end

  // R6: only the index offset may produce a set strobe
  assert_stray_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != IDX_OFF) |-> !stb.setStb);

  // R9: a clear needs a read of an aligned shared-register offset
  assert_clear_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStb |-> (rdEn && rdAddr[STRIDE_LSB-1:0] == '0));
endmodule

// File: rtl/msi_bank_dp.sv
module msi_bank_dp
  import msi_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [NUM_REGS-1:0][DATA_W-1:0] bank;
  logic [NUM_REGS-1:0][DATA_W-1:0] bankNxt;
  logic [NUM_REGS-1:0]             summary;
  logic [DATA_W-1:0]               setMask;

  assign setMask = DATA_W'(1) << stb.setBit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic setHit, clrHit;
    assign setHit = stb.setStb && (stb.setReg == SEL_W'(g));
    assign clrHit = stb.clrStb && (stb.clrReg == SEL_W'(g));
    always_comb bankNxt[g] = (clrHit ? '0 : bank[g]) | (setHit ? setMask : '0);
    always_ff @(posedge clk) begin
      if (!rstN) bank[g] <= '0;
      else       bank[g] <= bankNxt[g];
    end
    assign summary[g] = |bank[g];
  end

  assign irqOut = |summary;

  always_comb begin
    case (stb.rdSel)
      RD_BANK: rdData = bank[stb.clrReg];
      RD_SUM:  rdData = DATA_W'(summary);
      default: rdData = '0;
    endcase
  end

  // R2: the selected bit is set after an index write
  assert_set_visible_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setStb |=> bank[$past(stb.setReg)][$past(stb.setBit)]);

  // R3: a plain read clear empties the register
  assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrStb && !(stb.setStb && stb.setReg == stb.clrReg))
      |=> bank[$past(stb.clrReg)] == '0);

  // R7: a colliding set survives the clear, alone
  assert_collide_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrStb && stb.setStb && stb.setReg == stb.clrReg)
      |=> $countones(bank[$past(stb.clrReg)]) == 1);

  // R5: the request only rises after a set and only falls after a clear
  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(stb.setStb));
  assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(stb.clrStb));
endmodule

// File: rtl/msi_bank_top.sv
module msi_bank_top
  import msi_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int NUM_REGS = 8,
  parameter int STRIDE_LSB = 4,
  parameter logic [ADDR_W-1:0] IDX_OFF = 9'h140,
  parameter logic [ADDR_W-1:0] SUM_OFF = 9'h120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  strobe_t stb;

  msi_bank_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .STRIDE_LSB(STRIDE_LSB), .IDX_OFF(IDX_OFF), .SUM_OFF(SUM_OFF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .stb(stb)
  );

  msi_bank_dp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_msi_bank_top.sv
module tb_msi_bank_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [8:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [8:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [8];

  always #10 clk = ~clk;

  msi_bank_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] expSummary();
    logic [31:0] s = '0;
    for (int k = 0; k < 8; k++) s[k] = (model[k] != 0);
    return s;
  endfunction

  function automatic logic [31:0] expRead(input logic [8:0] a);
    if (a[3:0] == 0 && a < 9'h080) return model[a[6:4]];
    if (a == 9'h120) return expSummary();
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, check the read before the rising edge
  task automatic cycle(input logic we, input logic [8:0] wa, input logic [31:0] wd,
                       input logic re, input logic [8:0] ra, input string req);
    @(negedge clk);
    check("R5 irq level", {31'b0, irqOut}, {31'b0, (expSummary() != 0)});
    wrEn = we; wrAddr = wa; wrData = wd; rdEn = re; rdAddr = ra;
    #2;
    if (re) begin
      check(req, rdData, expRead(ra));
      if (ra[3:0] == 0 && ra < 9'h080) model[ra[6:4]] = '0;
    end
    if (we && wa == 9'h140) model[wd[31:29]][wd[28:24]] = 1'b1;
    @(posedge clk);
    #1;
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  function automatic logic [31:0] idxWord(input int r, input int b);
    return {3'(r), 5'(b), 24'h00A5A5};
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irqOut}, 32'd0);
    cycle(0, 0, 0, 1, 9'h120, "R1 summary after reset");
    cycle(0, 0, 0, 1, 9'h030, "R1 register after reset");
    // R2 set and R4 summary
    cycle(1, 9'h140, idxWord(3, 17), 0, 0, "R2");
    cycle(0, 0, 0, 1, 9'h120, "R4 summary one bit");
    // R8 OR preserves, repeat set is no-op
    cycle(1, 9'h140, idxWord(3, 2), 0, 0, "R8");
    cycle(1, 9'h140, idxWord(3, 2), 0, 0, "R8");
    cycle(0, 0, 0, 1, 9'h030, "R3 R8 read reg3 two bits");
    cycle(0, 0, 0, 1, 9'h030, "R3 reg3 cleared");
    // R6 stray writes
    cycle(1, 9'h000, 32'hFFFF_FFFF, 0, 0, "R6");
    cycle(1, 9'h120, 32'hFFFF_FFFF, 0, 0, "R6");
    cycle(1, 9'h070, 32'hE000_0000, 0, 0, "R6");
    cycle(0, 0, 0, 1, 9'h000, "R6 reg0 untouched");
    cycle(0, 0, 0, 1, 9'h120, "R6 summary untouched");
    // R9 unmapped reads
    cycle(1, 9'h140, idxWord(0, 31), 0, 0, "R2");
    cycle(0, 0, 0, 1, 9'h008, "R9 unaligned read");
    cycle(0, 0, 0, 1, 9'h080, "R9 beyond bank");
    cycle(0, 0, 0, 1, 9'h140, "R9 index read");
    cycle(0, 0, 0, 1, 9'h000, "R9 reg0 still full");
    // R7 collision on a register holding other bits
    cycle(1, 9'h140, idxWord(7, 0), 0, 0, "R2");
    cycle(1, 9'h140, idxWord(7, 9), 0, 0, "R2");
    cycle(1, 9'h140, idxWord(7, 30), 1, 9'h070, "R7 collide read");
    cycle(0, 0, 0, 1, 9'h070, "R7 only new bit");
    // R5 irq drops once drained
    cycle(0, 0, 0, 0, 0, "R5");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 5);
      int r  = $urandom_range(0, 7);
      int b  = $urandom_range(0, 31);
      int rr = $urandom_range(0, 7);
      case (op)
        0, 1: cycle(1, 9'h140, idxWord(r, b), 0, 0, "R2");
        2:    cycle(0, 0, 0, 1, 9'(rr * 16), "R3 random read");
        3:    cycle(1, 9'h140, idxWord(r, b), 1, 9'(rr * 16), "R7 random collide");
        4:    cycle(0, 0, 0, 1, 9'h120, "R4 random summary");
        default: cycle(1, 9'($urandom_range(0, 319)), $urandom, 1, 9'h120, "R6 random stray");
      endcase
    end
    for (int k = 0; k < 8; k++) cycle(0, 0, 0, 1, 9'(k * 16), "R3 drain");
    cycle(0, 0, 0, 1, 9'h120, "R4 empty summary");
    @(negedge clk);
    check("R5 irq low when drained", {31'b0, irqOut}, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule